// File: doc/BRIEF.md
# Two-Order Two-Bit Sequence Counter

This block is a small synchronous counter whose two state bits can be walked in either of two orders, picked by a single mode input. With mode low the state descends through plain binary values and wraps from the bottom back to the top. With mode high the same two bits advance through a reflected-code order, so exactly one bit toggles on every step. Both orders share one state register, and switching mode never clears it. The next step always begins from whatever value the register holds at that moment.

A wrap flag shows when the register sits on the final value of the order that mode currently selects. A user can count full passes with it or chain a slower stage from it. The flag is decoded from the registered state and the live mode input. A synchronous reset forces the register to zero, and a count enable freezes it when low. The state width is a parameter of at least two; its default of two gives the sequences listed below.

Top module: `seq_counter2`

## Requirements
- R1: While rst is high at a rising clock edge, state becomes 00 at that edge whatever en and mode are.
- R2: With rst low and en low at a clock edge, state keeps its value.
- R3: With rst low, en high and mode = 0, each edge takes state one step down in binary, wrapping from 00 to 11 (11, 10, 01, 00, 11 ...).
- R4: With rst low, en high and mode = 1, each edge takes state to the next value of the order 00, 01, 11, 10, after which it returns to 00.
- R5: When mode changes between two edges, the next state is the successor of the present state in the order the new mode selects, and the state is not cleared.
- R6: wrap is 1 exactly when mode = 0 and state = 00, or mode = 1 and state = 10; otherwise it is 0.
- R7: Every enabled step in mode 1 changes exactly one bit of state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, overrides en |
| en | input | 1 | Count enable; the state holds when low |
| mode | input | 1 | 0: binary down order, 1: reflected-code up order |
| state | output | W (2) | Registered counter state |
| wrap | output | 1 | High on the last value of the active order |

## Verification
The hardest situation to reach is a mode change that lands on a state from which the two orders give different successors, for example leaving 01 toward 00 under mode 0 and toward 11 under mode 1. The state must not be cleared when this happens. Random stimulus toggles mode often, but on its own it hits each state-and-mode pair only by chance. Directed sequences therefore park the counter on each of the four values and then flip mode just before the next enabled edge. Reset applied while enable is high is forced directly in the same way.

// File: rtl/seq_counter_pkg.sv
package seq_counter_pkg;

  typedef enum logic {
    ORDER_BIN_DOWN = 1'b0,
    ORDER_GRAY_UP  = 1'b1
  } order_e;

endpackage

// File: rtl/seq_gray_step.sv
module seq_gray_step #(
  parameter int W = 2
) (
  input  logic [W-1:0] cur_code,
  output logic [W-1:0] next_code
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cur_bin;
  logic [W-1:0] nxt_bin;

  // reflected code -> binary, MSB first chain
  assign cur_bin[W-1] = cur_code[W-1];
  genvar gi;
  generate
    for (gi = W - 2; gi >= 0; gi--) begin : g_unreflect
      assign cur_bin[gi] = cur_bin[gi+1] ^ cur_code[gi];
    end
  endgenerate

  assign nxt_bin   = cur_bin + ONE;
  assign next_code = nxt_bin ^ (nxt_bin >> 1);
endmodule

// File: rtl/seq_next.sv
module seq_next
  import seq_counter_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] cur,
  input  logic         en,
  input  order_e       order,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] gray_nxt;

  seq_gray_step #(.W(W)) u_gray (
    .cur_code  (cur),
    .next_code (gray_nxt)
  );

  always_comb begin
    nxt = cur;
    if (en) begin
      unique case (order)
        ORDER_BIN_DOWN: nxt = cur - ONE;
        ORDER_GRAY_UP:  nxt = gray_nxt;
        default:        nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/seq_wrap.sv
module seq_wrap
  import seq_counter_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] cur,
  input  order_e       order,
  output logic         last
);
  localparam logic [W-1:0] BIN_LAST  = '0;
  localparam logic [W-1:0] GRAY_LAST = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    unique case (order)
      ORDER_BIN_DOWN: last = (cur == BIN_LAST);
      ORDER_GRAY_UP:  last = (cur == GRAY_LAST);
      default:        last = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_counter2.sv
module seq_counter2
  import seq_counter_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         mode,
  output logic [W-1:0] state,
  output logic         wrap
);
  order_e       order;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  assign order = order_e'(mode);

  seq_next #(.W(W)) u_next (
    .cur   (state_q),
    .en    (en),
    .order (order),
    .nxt   (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  seq_wrap #(.W(W)) u_wrap (
    .cur   (state_q),
    .order (order),
    .last  (wrap)
  );

  assign state = state_q;
endmodule

// File: rtl/seq_counter2_chk.sv
module seq_counter2_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         mode,
  input logic [W-1:0] state,
  input logic         wrap
);
  localparam logic [W-1:0] ONE       = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] GRAY_LAST = {1'b1, {(W-1){1'b0}}};

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> state == '0);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !mode) |=> state == $past(state) - ONE);

  // R7
  one_bit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode) |=> $countones(state ^ $past(state)) == 1);

  // R6
  wrap_bin_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && state == '0) |-> wrap);

  // R6
  wrap_gray_chk: assert property (@(posedge clk) disable iff (rst)
    (mode && state == GRAY_LAST) |-> wrap);

  // R6
  wrap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (state == '0 || state == GRAY_LAST));
endmodule

bind seq_counter2 seq_counter2_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .mode  (mode),
  .state (state),
  .wrap  (wrap)
);

// File: tb/test_seq_counter2.sv
`timescale 1ns/1ps
module test_seq_counter2;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] state;
  logic       wrap;
  logic [1:0] exp_state = 2'b00;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  seq_counter2 #(.W(2)) i_seq_counter2 (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .state(state), .wrap(wrap)
  );

  function automatic logic [1:0] succ(input logic [1:0] s, input logic m);
    if (!m) begin
      case (s)
        2'b11: return 2'b10;
        2'b10: return 2'b01;
        2'b01: return 2'b00;
        default: return 2'b11;
      endcase
    end
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic exp_wrap(input logic [1:0] s, input logic m);
    return m ? (s == 2'b10) : (s == 2'b00);
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one clock: drive inputs, predict, check after the edge
  task automatic cyc(input logic r, input logic e, input logic m, input string tag);
    logic [1:0] prev;
    prev = exp_state;
    rst = r; en = e; mode = m;
    if (r)      exp_state = 2'b00;
    else if (e) exp_state = succ(exp_state, m);
    @(posedge clk); #1;
    chk(tag, state, exp_state);
    chk("R6", {1'b0, wrap}, {1'b0, exp_wrap(exp_state, mode)});
    if (!r && e && m) chk("R7", 2'(($countones(state ^ prev) == 1) ? 1 : 0), 2'd1);
  endtask

  task automatic park(input logic [1:0] target);
    int guard = 0;
    while (exp_state != target && guard < 8) begin
      cyc(1'b0, 1'b1, 1'b0, "R3");
      guard++;
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(posedge clk); #1;
    cyc(1'b1, 1'b1, 1'b1, "R1");            // reset beats enable
    chk("R1", state, 2'b00);
    // mode 0 full cycle from 00
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, "R3");
    // hold
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, i[0], "R2");
    // mode 1 full cycle
    cyc(1'b1, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, "R4");
    // mode switch from each parked value, both directions
    for (int t = 0; t < 4; t++) begin
      park(2'(t));
      cyc(1'b0, 1'b0, 1'b1, "R2");
      cyc(1'b0, 1'b1, 1'b1, "R5");
      cyc(1'b0, 1'b1, 1'b0, "R5");
    end
    // reset mid-count with enable high
    cyc(1'b0, 1'b1, 1'b0, "R3");
    cyc(1'b1, 1'b1, 1'b0, "R1");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic r, e, m;
      r = ($urandom % 16) == 0;
      e = ($urandom % 4) != 0;
      m = ($urandom % 3) == 0 ? ~mode : mode;
      cyc(r, e, m, r ? "R1" : (!e ? "R2" : (m != mode ? "R5" : (m ? "R4" : "R3"))));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule